// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Window Decoder

This block sits between a host programmed-I/O port and the register targets of a two-channel disk controller. Each access arrives with an address, a byte size, a direction and write data. The block compares the address against five address windows: the command block and the control block of each channel, and one shared bus-master register window. It picks the winning window, subtracts that window's base and hands the access to the matching target. The response reports one of five outcomes: routed, ignored, empty drive, decode error or size error.

The block keeps one drive selection per channel, either the master drive or the slave drive. It updates that selection by snooping writes to the drive-select register in each command block. When the selected drive is not present, a byte read is completed with zero data and a byte write is discarded. The bus-master window holds two equal register blocks, the lower block for channel 0 and the upper block for channel 1. The five window bases come from a configuration write port. The window sizes are parameters.

A small state machine sequences each access: IDLE accepts a request, LOOKUP decodes it, and REPLY presents the result for one cycle before returning to IDLE. The transitions are IDLE→LOOKUP on an accepted request, LOOKUP→REPLY always, and REPLY→IDLE always.

Top module: `ide_pio_decoder`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `tgt_valid` are 0, and both channels select the master drive, so `sel_drive` is 2'b00.
- R2: An access whose size is not 1, 2 or 4 bytes gets code 4 (size error) and reaches no target.
- R3: When `io_en` is 0, any legal-size access gets code 1 (ignored), reaches no target and leaves the drive selection unchanged.
- R4: Windows are tried in this order: channel 0 command (code 0, CMD_SIZE bytes), channel 0 control (code 1, CTL_SIZE), channel 1 command (code 2), channel 1 control (code 3), bus-master (code 4, BM_SIZE). A window is hit when base ≤ addr < base+size. The first hit wins, and `tgt_offset` = addr − base.
- R5: An address that hits no window gets code 3 (decode error), and `tgt_win` reads 7.
- R6: A write into the bus-master window while `bm_en` is 0 gets code 1 (ignored). Reads of that window are still routed.
- R7: In the bus-master window, an offset below BM_SIZE/2 goes to channel 0 at that offset. A higher offset goes to channel 1 at the offset minus BM_SIZE/2. `tgt_drive` is 0 for this window.
- R8: A legal-size write, with `io_en` set, to command-block offset 6 of a channel sets that channel's selection to data bit 4 (1 = slave). `sel_drive[c]` shows the selection of channel c.
- R9: `drv_present` bit 2·channel+drive marks an attached drive. A command or control access whose selected drive is absent gets code 2 (empty: a read returns zero, a write is discarded) when it is 1 byte, and code 4 otherwise. It is never routed.
- R10: A configuration write with value zero leaves the base unchanged. A nonzero value replaces base `cfg_idx`, where index k is window code k.
- R11: An accepted request yields `rsp_valid` for exactly one cycle, two clock edges later. `req_ready` is 0 from acceptance until the response has been shown. `tgt_valid` is high exactly when `rsp_valid` is high with code 0 (routed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O space enable |
| bm_en | input | 1 | Bus-master enable |
| cfg_we | input | 1 | Base register write strobe |
| cfg_idx | input | 3 | Base register index (window code) |
| cfg_base | input | AW | Base value to write |
| drv_present | input | 4 | Drive attached flags, bit 2·channel+drive |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Decoder idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | 0 routed, 1 ignored, 2 empty, 3 decode error, 4 size error |
| tgt_valid | output | 1 | Access issued to a target |
| tgt_win | output | 3 | Window code, 7 for none |
| tgt_chan | output | 1 | Channel of the target |
| tgt_drive | output | 1 | Selected drive, 1 = slave |
| tgt_offset | output | AW | Offset within the window or bus-master block |
| tgt_write | output | 1 | Direction passed through |
| tgt_size | output | 3 | Size passed through |
| tgt_wdata | output | 32 | Write data passed through |
| sel_drive | output | 2 | Current drive selection per channel |

## Verification
The bench targets several cases. It places overlapping bases to check that the earlier window in priority order wins; a decoder without that order would name the later window and give the wrong offset. It probes the first address past each window, where a closed-range compare would claim a hit instead of a decode error, and the split point of the bus-master window, where an off-by-one would send offset BM_SIZE/2 to the wrong channel. It writes the drive-select register while the newly chosen drive is absent, so a decoder that checked presence against the old selection would route the write. It also issues zero base writes, illegal sizes and bus-master writes with the enable clear. Each of these has a single correct outcome code that a wrong design would miss.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

    localparam int NUM_WIN   = 5;
    localparam int NUM_CH    = 2;
    localparam int WIN_IDX_W = 3;

    typedef enum logic [2:0] {
        RC_ROUTED  = 3'd0,
        RC_IGNORED = 3'd1,
        RC_EMPTY   = 3'd2,
        RC_DECERR  = 3'd3,
        RC_SIZEERR = 3'd4
    } rsp_code_e;

    typedef enum logic [2:0] {
        WIN_PCMD = 3'd0,
        WIN_PCTL = 3'd1,
        WIN_SCMD = 3'd2,
        WIN_SCTL = 3'd3,
        WIN_BM   = 3'd4,
        WIN_NONE = 3'd7
    } win_e;

    typedef enum logic [1:0] {
        FSM_IDLE   = 2'd0,
        FSM_LOOKUP = 2'd1,
        FSM_REPLY  = 2'd2
    } fsm_e;

endpackage

// File: rtl/ide_base_bank.sv
module ide_base_bank #(
    parameter int AW   = 16,
    parameter int NWIN = 5,
    parameter int IW   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IW-1:0]            cfg_idx,
    input  logic [AW-1:0]            cfg_base,
    output logic [NWIN-1:0][AW-1:0]  bases
);
    for (genvar i = 0; i < NWIN; i++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bases[i] <= '0;
            end else if (cfg_we && (cfg_idx == IW'(i)) && (cfg_base != '0)) begin
                bases[i] <= cfg_base;
            end
        end
    end
endmodule

// File: rtl/ide_win_match.sv
module ide_win_match #(
    parameter int AW   = 16,
    parameter int SIZE = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic [AW-1:0] offset
);
    logic [AW:0] addr_x;
    logic [AW:0] lo_x;
    logic [AW:0] hi_x;

    always_comb begin
        addr_x = {1'b0, addr};
        lo_x   = {1'b0, base};
        hi_x   = lo_x + (AW+1)'(SIZE);
        hit    = (addr_x >= lo_x) && (addr_x < hi_x);
        offset = addr - base;
    end
endmodule

// File: rtl/ide_drive_sel.sv
module ide_drive_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic val,
    output logic sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 1'b0;
        end else if (upd) begin
            sel <= val;
        end
    end
endmodule

// File: rtl/ide_pio_decoder.sv
module ide_pio_decoder
    import ide_dec_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_SIZE  = 16,
    parameter int SEL_OFF  = 6,
    parameter int SEL_BIT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          bm_en,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_idx,
    input  logic [AW-1:0] cfg_base,
    input  logic [3:0]    drv_present,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [2:0]    rsp_code,
    output logic          tgt_valid,
    output logic [2:0]    tgt_win,
    output logic          tgt_chan,
    output logic          tgt_drive,
    output logic [AW-1:0] tgt_offset,
    output logic          tgt_write,
    output logic [2:0]    tgt_size,
    output logic [31:0]   tgt_wdata,
    output logic [1:0]    sel_drive
);
    localparam int BM_BLK = BM_SIZE / 2;

    fsm_e state_q, state_d;

    // Latched request
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [2:0]    size_q;
    logic [31:0]   wdata_q;
    logic          io_q;
    logic          bm_q;

    // Decode results
    rsp_code_e     code_q, code_d;
    win_e          win_q, win_d;
    logic          chan_q, chan_d;
    logic          drv_q, drv_d;
    logic [AW-1:0] off_q, off_d;

    logic [NUM_WIN-1:0][AW-1:0] bases;
    logic [NUM_WIN-1:0]         hits;
    logic [NUM_WIN-1:0][AW-1:0] offs;
    logic [NUM_CH-1:0]          sel_upd;
    logic                       size_ok;
    logic                       any_hit;
    logic [AW-1:0]              raw_off;
    logic                       is_cmd;
    logic                       is_bm;
    logic                       present;

    ide_base_bank #(.AW(AW), .NWIN(NUM_WIN), .IW(WIN_IDX_W)) u_bases (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .bases    (bases)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int SZ = (w == NUM_WIN - 1) ? BM_SIZE :
                            ((w % 2) == 0)     ? CMD_SIZE : CTL_SIZE;
        ide_win_match #(.AW(AW), .SIZE(SZ)) u_match (
            .addr   (addr_q),
            .base   (bases[w]),
            .hit    (hits[w]),
            .offset (offs[w])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        ide_drive_sel u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (sel_upd[c]),
            .val   (wdata_q[SEL_BIT]),
            .sel   (sel_drive[c])
        );
    end

    // Window priority: lowest index wins
    always_comb begin
        win_d   = WIN_NONE;
        raw_off = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win_d   = win_e'(i[2:0]);
                raw_off = offs[i];
            end
        end
        any_hit = |hits;
    end

    // Access classification
    always_comb begin
        size_ok = (size_q == 3'd1) || (size_q == 3'd2) || (size_q == 3'd4);
        is_cmd  = (win_d == WIN_PCMD) || (win_d == WIN_SCMD);
        is_bm   = (win_d == WIN_BM);

        unique case (win_d)
            WIN_PCMD, WIN_PCTL: chan_d = 1'b0;
            WIN_SCMD, WIN_SCTL: chan_d = 1'b1;
            WIN_BM:             chan_d = (raw_off >= AW'(BM_BLK));
            default:            chan_d = 1'b0;
        endcase

        off_d = (is_bm && chan_d) ? (raw_off - AW'(BM_BLK)) : raw_off;

        sel_upd = '0;
        if ((state_q == FSM_LOOKUP) && size_ok && io_q && is_cmd && wr_q &&
            (raw_off == AW'(SEL_OFF))) begin
            sel_upd[chan_d] = 1'b1;
        end

        if (is_bm || !any_hit) begin
            drv_d = 1'b0;
        end else if (sel_upd[chan_d]) begin
            drv_d = wdata_q[SEL_BIT];
        end else begin
            drv_d = sel_drive[chan_d];
        end

        present = drv_present[{chan_d, drv_d}];

        if (!size_ok) begin
            code_d = RC_SIZEERR;
        end else if (!io_q) begin
            code_d = RC_IGNORED;
        end else if (!any_hit) begin
            code_d = RC_DECERR;
        end else if (is_bm && wr_q && !bm_q) begin
            code_d = RC_IGNORED;
        end else if (!is_bm && !present) begin
            code_d = (size_q == 3'd1) ? RC_EMPTY : RC_SIZEERR;
        end else begin
            code_d = RC_ROUTED;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE:   if (req_valid) state_d = FSM_LOOKUP;
            FSM_LOOKUP: state_d = FSM_REPLY;
            FSM_REPLY:  state_d = FSM_IDLE;
            default:    state_d = FSM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
            io_q    <= 1'b0;
            bm_q    <= 1'b0;
            code_q  <= RC_ROUTED;
            win_q   <= WIN_NONE;
            chan_q  <= 1'b0;
            drv_q   <= 1'b0;
            off_q   <= '0;
        end else begin
            unique case (state_q)
                FSM_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        addr_q  <= req_addr;
                        size_q  <= req_size;
                        wdata_q <= req_wdata;
                        io_q    <= io_en;
                        bm_q    <= bm_en;
                    end
                end
                FSM_LOOKUP: begin
                    code_q <= code_d;
                    win_q  <= win_d;
                    chan_q <= chan_d;
                    drv_q  <= drv_d;
                    off_q  <= off_d;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == FSM_IDLE);
        rsp_valid  = (state_q == FSM_REPLY);
        rsp_code   = code_q;
        tgt_valid  = (state_q == FSM_REPLY) && (code_q == RC_ROUTED);
        tgt_win    = win_q;
        tgt_chan   = chan_q;
        tgt_drive  = drv_q;
        tgt_offset = off_q;
        tgt_write  = wr_q;
        tgt_size   = size_q;
        tgt_wdata  = wdata_q;
    end

endmodule

// File: rtl/ide_pio_decoder_chk.sv
module ide_pio_decoder_chk #(
    parameter int AW       = 16,
    parameter int CMD_SIZE = 8,
    parameter int CTL_SIZE = 4,
    parameter int BM_SIZE  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [2:0]    rsp_code,
    input logic          tgt_valid,
    input logic [2:0]    tgt_win,
    input logic [AW-1:0] tgt_offset,
    input logic [2:0]    tgt_size,
    input logic [1:0]    sel_drive
);
    assert_reset_master_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_drive == 2'b00));

    assert_legal_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> ((tgt_size == 3'd1) || (tgt_size == 3'd2) || (tgt_size == 3'd4)));

    assert_cmd_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && ((tgt_win == 3'd0) || (tgt_win == 3'd2))) |-> (tgt_offset < AW'(CMD_SIZE)));

    assert_ctl_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && ((tgt_win == 3'd1) || (tgt_win == 3'd3))) |-> (tgt_offset < AW'(CTL_SIZE)));

    assert_bm_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && (tgt_win == 3'd4)) |-> (tgt_offset < AW'(BM_SIZE / 2)));

    assert_decerr_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == 3'd3)) |-> (tgt_win == 3'd7));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_tgt_routed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (rsp_valid && (rsp_code == 3'd0)));
endmodule

bind ide_pio_decoder ide_pio_decoder_chk #(
    .AW(AW), .CMD_SIZE(CMD_SIZE), .CTL_SIZE(CTL_SIZE), .BM_SIZE(BM_SIZE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .tgt_valid  (tgt_valid),
    .tgt_win    (tgt_win),
    .tgt_offset (tgt_offset),
    .tgt_size   (tgt_size),
    .sel_drive  (sel_drive)
);

// File: tb/ide_pio_decoder_test.sv
module ide_pio_decoder_test;
    localparam int AW = 16;
    localparam int CMD_SZ = 8;
    localparam int CTL_SZ = 4;
    localparam int BM_SZ = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b1;
    logic          bm_en = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [3:0]    drv_present = 4'b0111;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = 3'd1;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_code;
    logic          tgt_valid;
    logic [2:0]    tgt_win;
    logic          tgt_chan;
    logic          tgt_drive;
    logic [AW-1:0] tgt_offset;
    logic          tgt_write;
    logic [2:0]    tgt_size;
    logic [31:0]   tgt_wdata;
    logic [1:0]    sel_drive;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [AW-1:0] m_base [5];
    logic          m_sel  [2];

    ide_pio_decoder uut (.*);

    always #4 clk = ~clk;

    function automatic int win_size(int w);
        if (w == 4) return BM_SZ;
        if ((w % 2) == 0) return CMD_SZ;
        return CTL_SZ;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(int idx, logic [AW-1:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_base = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (val != '0) m_base[idx] = val;
    endtask

    task automatic access(logic wr, logic [AW-1:0] a, logic [2:0] sz, logic [31:0] d);
        int e_code, e_win, e_chan, e_drv, e_off;
        string tag;
        int w;
        int off;
        logic size_ok;
        logic upd;
        e_win = 7; e_chan = 0; e_drv = 0; e_off = 0; w = 7; off = 0; upd = 1'b0;
        for (int i = 4; i >= 0; i--) begin
            if ((int'(a) >= int'(m_base[i])) && (int'(a) < int'(m_base[i]) + win_size(i))) begin
                w = i; off = int'(a) - int'(m_base[i]);
            end
        end
        size_ok = (sz == 1) || (sz == 2) || (sz == 4);
        if (w != 7) begin
            e_win = w;
            e_chan = (w == 4) ? int'(off >= BM_SZ / 2) : w / 2;
            e_off = (w == 4 && e_chan == 1) ? off - BM_SZ / 2 : off;
            if (w != 4) begin
                upd = size_ok && io_en && wr && ((w % 2) == 0) && (off == 6);
                e_drv = upd ? int'(d[4]) : int'(m_sel[e_chan]);
            end
        end
        if (!size_ok) begin e_code = 4; tag = "R2"; end
        else if (!io_en) begin e_code = 1; tag = "R3"; end
        else if (w == 7) begin e_code = 3; tag = "R5"; end
        else if (w == 4 && wr && !bm_en) begin e_code = 1; tag = "R6"; end
        else if (w != 4 && !drv_present[e_chan * 2 + e_drv]) begin
            e_code = (sz == 1) ? 2 : 4; tag = "R9";
        end else begin e_code = 0; tag = (w == 4) ? "R7" : "R4"; end
        if (upd) begin m_sel[e_chan] = d[4]; tag = {tag, "/R8"}; end

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 ready low while busy", {31'd0, req_ready}, 32'd0);
        chk("R11 no early response", {31'd0, rsp_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R11 response strobe", {31'd0, rsp_valid}, 32'd1);
        chk({tag, " code"}, {29'd0, rsp_code}, e_code);
        chk({tag, " R11 target strobe"}, {31'd0, tgt_valid}, {31'd0, e_code == 0});
        chk({tag, " window"}, {29'd0, tgt_win}, e_win);
        if (e_code == 0) begin
            chk({tag, " channel"}, {31'd0, tgt_chan}, e_chan);
            chk({tag, " drive"}, {31'd0, tgt_drive}, e_drv);
            chk({tag, " offset"}, {16'd0, tgt_offset}, e_off);
        end
        chk({tag, " selection"}, {30'd0, sel_drive}, {30'd0, m_sel[1], m_sel[0]});
        @(posedge clk);
        @(negedge clk);
        chk("R11 single-cycle response", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] sizes [8];
        sizes = '{3'd1, 3'd2, 3'd4, 3'd1, 3'd1, 3'd3, 3'd0, 3'd2};
        void'($urandom(32'd2024));
        for (int i = 0; i < 5; i++) m_base[i] = '0;
        m_sel[0] = 1'b0; m_sel[1] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 tgt_valid", {31'd0, tgt_valid}, 32'd0);
        chk("R1 selection", {30'd0, sel_drive}, 32'd0);

        cfg_write(0, 16'h01F0);
        cfg_write(1, 16'h03F6);
        cfg_write(2, 16'h0170);
        cfg_write(3, 16'h0376);
        cfg_write(4, 16'hC000);

        // R10: zero write keeps the old base
        cfg_write(0, 16'h0000);
        access(1'b0, 16'h01F2, 3'd1, 32'd0);

        // R4 edges: last byte in, first byte past
        access(1'b0, 16'h01F7, 3'd1, 32'd0);
        access(1'b0, 16'h01F8, 3'd1, 32'd0);
        access(1'b0, 16'h03F9, 3'd2, 32'd0);
        access(1'b0, 16'h03FA, 3'd1, 32'd0);

        // R4 priority: overlap channel 0 control onto its command block
        cfg_write(1, 16'h01F4);
        access(1'b0, 16'h01F5, 3'd1, 32'd0);
        cfg_write(1, 16'h03F6);

        // R7 split point
        access(1'b0, 16'hC007, 3'd1, 32'd0);
        access(1'b0, 16'hC008, 3'd4, 32'd0);
        access(1'b0, 16'hC010, 3'd1, 32'd0);

        // R6 bus-master writes with enable clear
        bm_en = 1'b0;
        access(1'b1, 16'hC002, 3'd1, 32'h5A);
        access(1'b0, 16'hC002, 3'd1, 32'd0);
        bm_en = 1'b1;

        // R8, R9: select absent slave on channel 1, then back
        access(1'b1, 16'h0176, 3'd1, 32'h10);
        access(1'b0, 16'h0170, 3'd2, 32'd0);
        access(1'b0, 16'h0377, 3'd1, 32'd0);
        access(1'b1, 16'h0176, 3'd1, 32'h00);
        access(1'b1, 16'h01F6, 3'd1, 32'h10);

        // R3 I/O disabled: select write has no effect
        io_en = 1'b0;
        access(1'b1, 16'h01F6, 3'd1, 32'h00);
        io_en = 1'b1;

        // R2 illegal sizes
        access(1'b0, 16'h01F0, 3'd3, 32'd0);
        access(1'b1, 16'hC000, 3'd0, 32'd0);

        for (int n = 0; n < 600; n++) begin
            int w;
            logic [AW-1:0] a;
            w = int'($urandom % 6);
            if (w < 5) a = m_base[w] + AW'($urandom % (win_size(w) + 3)) - AW'(1);
            else a = AW'($urandom);
            io_en = ($urandom % 10) != 0;
            bm_en = ($urandom % 4) != 0;
            if (n == 300) drv_present = 4'b1010;
            access(1'($urandom), a, sizes[$urandom % 8], $urandom);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule